// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block drives a synchronous single-port RAM through one of four built-in test algorithms. It works over an inclusive address window given by a low and a high bound. The RAM returns read data one clock after the address is presented. The sequencer drives the address, the write enable and the write data, and compares what comes back against a value it derives from the algorithm.

A one-cycle `start` pulse latches the algorithm select and the window, then raises `busy`. The run ends in one of two ways. If every step completes, `done` rises with `fail` low. At the first miscompare the sequencer stops immediately, raises `done` and `fail` together, and keeps the failing address, the expected word and the word that was read. These results stay on the outputs until the next accepted `start`.

Top module: `mem_selftest`

## Requirements
- R1: A `start` pulse seen while the block is idle or finished latches `mode`, `lo_addr` and `hi_addr`. In the next cycle `busy` is 1 and both `done` and `fail` are 0.
- R2: A `start` pulse seen while `busy` is 1 changes nothing. The running test ends with the result and memory contents of the algorithm and window it was started with.
- R3: With `mode`=0 (address-as-data), the window is cleared to zero. Each word is then written with its own address, zero-extended. The words are verified upward, then verified again downward. A clean run leaves each word equal to its address.
- R4: With `mode`=1 (fixed patterns), four rounds run in order with 0x00000000, 0xFFFFFFFF, 0x55555555 and 0xAAAAAAAA. Each round fills the window upward and then verifies it upward. A clean run leaves 0xAAAAAAAA.
- R5: With `mode`=2 (walking one), there are 32 rounds. Round k clears the window, writes the word with only bit k set, and verifies it, for k = 0 to 31. A clean run leaves 0x80000000.
- R6: With `mode`=3 (march), the window is first filled with 0x55555555. An upward pass then checks each word for 0x55555555 and writes 0xAAAAAAAA to it. A downward pass checks each word for 0xAAAAAAAA and writes 0x55555555 back. A clean run leaves 0x55555555.
- R7: Each checked location takes two cycles. The address is held while the read word arrives, and it is compared in the second cycle. Each pass costs one set-up cycle. A clean run therefore keeps `busy` high for 4+6N cycles in mode 0, and 3+5N cycles in mode 3, where N is the number of words in the window.
- R8: At the first miscompare the block stops issuing accesses and does not perform that location's write-back. It raises `done` and `fail` together, and presents the failing address on `fail_addr`, the expected word on `fail_exp` and the read word on `fail_act`.
- R9: While `start` stays low, `done`, `fail` and the captured failure record hold their values.
- R10: Writes occur only while `busy` is 1, and only to addresses within `[lo_addr, hi_addr]`. Words outside the window are left unchanged. When `lo_addr` equals `hi_addr`, exactly that one word is tested.
- R11: After reset, `busy`, `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse |
| mode | input | 2 | Algorithm select: 0 address-as-data, 1 fixed patterns, 2 walking one, 3 march |
| lo_addr | input | AW | First word of the window |
| hi_addr | input | AW | Last word of the window (must be at least `lo_addr`) |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished; held until the next start |
| fail | output | 1 | A miscompare stopped the test |
| fail_addr | output | AW | Address of the first miscompare |
| fail_exp | output | DW | Word the algorithm expected there |
| fail_act | output | DW | Word the RAM returned |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after the address |

## Verification
Some properties are checked on every cycle by the assertions. These are: `busy` and `done` are never high together, `fail` never appears without `done`, and the result and failure record hold steady after the finish. A launch clears the flags, a start during a run leaves the latched settings untouched, and every write stays inside the latched window. Other behaviours can only be shown by the bench's scenarios against its own reference model. These are the data order of each algorithm, the final memory image, the two-cycle read compare and its cycle totals, and which address and words the first stuck-at fault yields. They are exercised with directed single-word windows, start pulses injected mid-run, and randomly placed stuck bits.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        MODE_UNIQ  = 2'd0,
        MODE_PAT   = 2'd1,
        MODE_SLIDE = 2'd2,
        MODE_MARCH = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RMW   = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        SRC_ZERO = 3'd0,
        SRC_ADDR = 3'd1,
        SRC_ITER = 3'd2,
        SRC_BG   = 3'd3,
        SRC_BGN  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    // One sweep over the window: what it does, which way, and which data
    typedef struct packed {
        op_e  op;
        logic down;
        src_e src;
    } pass_t;

    function automatic pass_t pass_of(mode_e m, logic [1:0] step);
        pass_t p;
        p = '{op: OP_WRITE, down: 1'b0, src: SRC_ZERO};
        case (m)
            MODE_UNIQ: case (step)
                2'd0:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_ZERO};
                2'd1:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_ADDR};
                2'd2:    p = '{op: OP_READ,  down: 1'b0, src: SRC_ADDR};
                default: p = '{op: OP_READ,  down: 1'b1, src: SRC_ADDR};
            endcase
            MODE_PAT: case (step)
                2'd0:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_ITER};
                default: p = '{op: OP_READ,  down: 1'b0, src: SRC_ITER};
            endcase
            MODE_SLIDE: case (step)
                2'd0:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_ZERO};
                2'd1:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_ITER};
                default: p = '{op: OP_READ,  down: 1'b0, src: SRC_ITER};
            endcase
            default: case (step)
                2'd0:    p = '{op: OP_WRITE, down: 1'b0, src: SRC_BG};
                2'd1:    p = '{op: OP_RMW,   down: 1'b0, src: SRC_BG};
                default: p = '{op: OP_RMW,   down: 1'b1, src: SRC_BGN};
            endcase
        endcase
        return p;
    endfunction

    function automatic logic [1:0] last_step(mode_e m);
        case (m)
            MODE_UNIQ: return 2'd3;
            MODE_PAT:  return 2'd1;
            default:   return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          down,
    input  logic          adv,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= down ? hi : lo;
        end else if (adv) begin
            addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_last = down ? (addr == lo) : (addr == hi);
endmodule

// File: rtl/mbist_capture.sv
module mbist_capture #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          check,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] exp_word,
    input  logic [DW-1:0] actual,
    output logic          mismatch,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);
    assign mismatch = (actual != exp_word);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (check && mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= exp_word;
            fail_act  <= actual;
        end
    end
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
    import mbist_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] lo_addr,
    input  logic [AW-1:0] hi_addr,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int            IW         = $clog2(DW);
    localparam logic [DW-1:0] BG         = {(DW/2){2'b01}};
    localparam logic [IW-1:0] SLIDE_LAST = IW'(DW - 1);

    state_e        state_q;
    mode_e         mode_q;
    logic [AW-1:0] lo_q, hi_q;
    logic [1:0]    step_q;
    logic [IW-1:0] iter_q;
    logic          wait_q;

    pass_t         cur;
    logic [DW-1:0] iter_word, src_val;
    logic [IW-1:0] last_iter;
    logic          run, is_wr, check, mismatch, at_last;
    logic          loc_done, pass_end, iter_end, all_end, accept;

    assign cur    = pass_of(mode_q, step_q);
    assign run    = (state_q == ST_RUN);
    assign is_wr  = (cur.op == OP_WRITE);
    assign accept = start && (state_q == ST_IDLE || state_q == ST_FIN);

    // Word used by the current round of the pattern and walking-one modes
    always_comb begin
        if (mode_q == MODE_SLIDE) begin
            iter_word = DW'(1) << iter_q;
        end else begin
            case (iter_q[1:0])
                2'd0:    iter_word = '0;
                2'd1:    iter_word = '1;
                2'd2:    iter_word = BG;
                default: iter_word = ~BG;
            endcase
        end
    end

    always_comb begin
        case (cur.src)
            SRC_ADDR: src_val = DW'(mem_addr);
            SRC_ITER: src_val = iter_word;
            SRC_BG:   src_val = BG;
            SRC_BGN:  src_val = ~BG;
            default:  src_val = '0;
        endcase
    end

    always_comb begin
        case (mode_q)
            MODE_PAT:   last_iter = IW'(3);
            MODE_SLIDE: last_iter = SLIDE_LAST;
            default:    last_iter = '0;
        endcase
    end

    // A read location finishes on its second cycle, a write location on its first
    assign check    = run && !is_wr && wait_q;
    assign loc_done = run && (is_wr || wait_q);
    assign pass_end = loc_done && at_last;
    assign iter_end = pass_end && (step_q == last_step(mode_q));
    assign all_end  = iter_end && (iter_q == last_iter);

    assign mem_we    = run && (is_wr || (cur.op == OP_RMW && wait_q && !mismatch));
    assign mem_wdata = is_wr ? src_val : ~src_val;

    mbist_addr_seq #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (state_q == ST_LOAD),
        .down    (cur.down),
        .adv     (loc_done && !at_last && !(check && mismatch)),
        .lo      (lo_q),
        .hi      (hi_q),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    mbist_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .check     (check),
        .addr      (mem_addr),
        .exp_word  (src_val),
        .actual    (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_UNIQ;
            lo_q    <= '0;
            hi_q    <= '0;
            step_q  <= '0;
            iter_q  <= '0;
            wait_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        state_q <= ST_LOAD;
                        mode_q  <= mode_e'(mode);
                        lo_q    <= lo_addr;
                        hi_q    <= hi_addr;
                        step_q  <= '0;
                        iter_q  <= '0;
                        wait_q  <= 1'b0;
                    end
                end
                ST_LOAD: state_q <= ST_RUN;
                ST_RUN: begin
                    if (check && mismatch) begin
                        state_q <= ST_FIN;
                    end else begin
                        if (!is_wr) wait_q <= !wait_q;
                        if (pass_end) begin
                            if (all_end) begin
                                state_q <= ST_FIN;
                            end else begin
                                state_q <= ST_LOAD;
                                if (iter_end) begin
                                    step_q <= '0;
                                    iter_q <= iter_q + 1'b1;
                                end else begin
                                    step_q <= step_q + 1'b1;
                                end
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_LOAD) || run;
    assign done = (state_q == ST_FIN);
endmodule

// File: rtl/mbist_checker.sv
module mbist_checker #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] lo_q,
    input logic [AW-1:0] hi_q,
    input logic [1:0]    mode_q,
    input logic [AW-1:0] fail_addr,
    input logic [DW-1:0] fail_exp,
    input logic [DW-1:0] fail_act
);
    assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_launch_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !fail));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> ($stable(lo_q) && $stable(hi_q) && $stable(mode_q)));

    assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    assert_result_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_addr)
                              && $stable(fail_exp) && $stable(fail_act)));

    assert_write_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && mem_addr >= lo_q && mem_addr <= hi_q));
endmodule

bind mem_selftest mbist_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .mode_q    (mode_q),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
);

// File: tb/mem_selftest_test.sv
module mem_selftest_test;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [1:0]    mode;
    logic [AW-1:0] lo, hi;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] fail_exp, fail_act, mem_wdata, mem_rdata;
    logic          mem_we;

    int total = 0;
    int bad   = 0;
    bit over  = 0;

    // stuck-at fault in the bench RAM
    bit   flt_on;
    int   flt_addr, flt_bit;
    logic flt_val;

    logic [DW-1:0] ram  [NW];
    logic [DW-1:0] refm [NW];
    bit            r_fail;
    int            r_addr;
    logic [DW-1:0] r_exp, r_act;

    always #2 clk = ~clk;  // 250 MHz

    mem_selftest #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .lo_addr(lo), .hi_addr(hi), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] stuck(int a, logic [DW-1:0] d);
        if (flt_on && a == flt_addr) d[flt_bit] = flt_val;
        return d;
    endfunction

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= stuck(int'(mem_addr), mem_wdata);
        mem_rdata <= stuck(int'(mem_addr), ram[mem_addr]);
    end

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!over) begin
            over = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reference model of the four algorithms, written from the requirements
    task automatic rwr(int a, logic [DW-1:0] d);
        if (!r_fail) refm[a] = stuck(a, d);
    endtask

    task automatic rchk(int a, logic [DW-1:0] e);
        logic [DW-1:0] v;
        if (r_fail) return;
        v = stuck(a, refm[a]);
        if (v !== e) begin
            r_fail = 1; r_addr = a; r_exp = e; r_act = v;
        end
    endtask

    task automatic ref_run(int m, int a_lo, int a_hi);
        logic [DW-1:0] bgw;
        logic [DW-1:0] pats [4];
        bgw = 32'h5555_5555;
        pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5555_5555; pats[3] = 32'hAAAA_AAAA;
        r_fail = 0;
        case (m)
            0: begin
                for (int a = a_lo; a <= a_hi; a++) rwr(a, 0);
                for (int a = a_lo; a <= a_hi; a++) rwr(a, a);
                for (int a = a_lo; a <= a_hi; a++) rchk(a, a);
                for (int a = a_hi; a >= a_lo; a--) rchk(a, a);
            end
            1: for (int p = 0; p < 4; p++) begin
                for (int a = a_lo; a <= a_hi; a++) rwr(a, pats[p]);
                for (int a = a_lo; a <= a_hi; a++) rchk(a, pats[p]);
            end
            2: for (int k = 0; k < DW; k++) begin
                for (int a = a_lo; a <= a_hi; a++) rwr(a, 0);
                for (int a = a_lo; a <= a_hi; a++) rwr(a, 32'h1 << k);
                for (int a = a_lo; a <= a_hi; a++) rchk(a, 32'h1 << k);
            end
            default: begin
                for (int a = a_lo; a <= a_hi; a++) rwr(a, bgw);
                for (int a = a_lo; a <= a_hi; a++) begin rchk(a, bgw); rwr(a, ~bgw); end
                for (int a = a_hi; a >= a_lo; a--) begin rchk(a, ~bgw); rwr(a, bgw); end
            end
        endcase
    endtask

    function automatic int busy_cycles(int m, int n);
        case (m)
            0:       return 4 + 6 * n;
            1:       return 4 * (2 + 3 * n);
            2:       return DW * (3 + 4 * n);
            default: return 3 + 5 * n;
        endcase
    endfunction

    function automatic string mreq(int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_case(int m, int a_lo, int a_hi, bit disturb, string req);
        int cyc;
        bit ok;
        for (int i = 0; i < NW; i++) refm[i] = ram[i];
        ref_run(m, a_lo, a_hi);
        mode = 2'(m); lo = AW'(a_lo); hi = AW'(a_hi); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !fail, "R1", "launch flags", {busy, done, fail}, 3'b100);
        cyc = 0;
        while (!done && cyc < 60000) begin
            cyc++;
            if (disturb && cyc == 3) begin
                start = 1'b1; mode = 2'((m + 1) % 4); lo = '0; hi = AW'(NW - 1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done, req, "run finished", done, 1);
        check(fail == r_fail, "R8", "fail flag", fail, r_fail);
        if (r_fail) begin
            check(fail_addr == AW'(r_addr), "R8", "fail_addr", fail_addr, r_addr);
            check(fail_exp === r_exp, "R8", "fail_exp", fail_exp, r_exp);
            check(fail_act === r_act, "R8", "fail_act", fail_act, r_act);
        end
        ok = 1;
        for (int i = 0; i < NW; i++) if (ram[i] !== refm[i]) ok = 0;
        check(ok, disturb ? "R2" : req, "memory image", ok, 1);
        if (!r_fail && !disturb)
            check(cyc == busy_cycles(m, a_hi - a_lo + 1), "R7", "busy cycles",
                  cyc, busy_cycles(m, a_hi - a_lo + 1));
        repeat (8) @(negedge clk);
        check(done && fail == r_fail && (!r_fail || fail_addr == AW'(r_addr)), "R9",
              "result held", {done, fail}, {1'b1, r_fail});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; start = 1'b0; mode = '0; lo = '0; hi = '0;
        flt_on = 0; flt_addr = 0; flt_bit = 0; flt_val = 1'b0;
        for (int i = 0; i < NW; i++) ram[i] = $urandom;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail, "R11", "reset flags", {busy, done, fail}, 3'b000);
        rst = 1'b0;
        @(negedge clk);

        // clean runs of every algorithm, including cycle totals
        run_case(0, 4, 19, 0, "R3");
        run_case(1, 10, 30, 0, "R4");
        run_case(2, 0, 11, 0, "R5");
        run_case(3, 20, 47, 0, "R6");

        // single-word window, clean and with a fault on that word (R10)
        run_case(3, 9, 9, 0, "R10");
        flt_on = 1; flt_addr = 9; flt_bit = 3; flt_val = 1'b0;
        run_case(3, 9, 9, 0, "R10");
        flt_addr = 10;
        run_case(1, 9, 9, 0, "R10");

        // directed faults on each algorithm (R8)
        flt_addr = 17; flt_bit = 31; flt_val = 1'b1;
        run_case(0, 12, 25, 0, "R3");
        flt_addr = 40; flt_bit = 0; flt_val = 1'b0;
        run_case(3, 33, 50, 0, "R6");
        flt_addr = 5; flt_bit = 20; flt_val = 1'b1;
        run_case(2, 2, 8, 0, "R5");
        flt_on = 0;

        // start while busy must be ignored (R2)
        run_case(1, 0, 15, 1, "R2");
        run_case(3, 30, 40, 1, "R2");

        // random windows, modes and faults
        for (int n = 0; n < 10; n++) begin
            int m, a, b;
            m = int'($urandom % 4);
            a = int'($urandom % NW);
            b = a + int'($urandom % (NW - a));
            if (b - a > 20) b = a + 20;
            flt_on   = ($urandom % 2) == 1;
            flt_addr = a + int'($urandom % (b - a + 1));
            flt_bit  = int'($urandom % DW);
            flt_val  = 1'($urandom % 2);
            run_case(m, a, b, 0, mreq(m));
        end
        flt_on = 0;
        finish_up();
    end
endmodule